// File: doc/BRIEF.md
# Drive Password Lock Controller

This block decides whether a storage device may touch its media. It keeps a user password, a master password and a security level (high or maximum). Whenever a user password is armed, every power-on leaves the device locked. A host command decoder hands it abstracted security commands: set password, unlock, erase prepare, erase unit, disable password and freeze lock. Each command carries a 16-word password, an identifier bit and a level bit. For each command the block returns exactly one accept or abort response. It also drives a `media_ok` flag that the decoder uses to gate read and write commands.

The stored password is compared with the supplied one word by word. The walk always covers every word, so the response latency does not reveal where the first mismatch sits. At the high level the master password can unlock the device. At the maximum level the master password acts only through an erase unit command that directly follows an erase prepare. That path raises a one-cycle wipe request and disarms the user password. Failed unlocks are counted, and once the limit is reached further unlock and erase attempts abort. A freeze lock blocks every security change until the next power-on. Power-on is signalled on `power_cycle`. It keeps the stored passwords, which model non-volatile storage, and clears the volatile state. `rst_n` models first-time initialisation.

Top module: `pwlock_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, no user password is armed, the level is high, `media_ok` is 1, `busy` is 0 and `rsp_valid` is 0. Word i of the master password is `MASTER_SEED ^ i` (word i occupies bits [16i+15:16i] of a password bus).
- R2: A command presented on `cmd_valid` while `busy` is 0 is captured at that rising edge. Its single-cycle `rsp_valid` pulse appears after the (NWORDS+1)th rising edge following capture, whatever the password contents and wherever a mismatch lies. `cmd_valid` while `busy` is 1 is ignored.
- R3: Opcode 0 (any non-security command) is always accepted. Like every command other than erase prepare, it cancels a pending erase prepare.
- R4: A `power_cycle` pulse has the following effects:
  - it keeps the stored passwords and level;
  - it enters the locked state if a user password is armed, and the unlocked state otherwise;
  - it clears the failure count and any pending prepare;
  - it drops an in-flight command without a response, even when the pulse falls in that command's decision cycle.
- R5: `media_ok` is 0 exactly while the device is locked, and it is always 1 while no user password is armed.
- R6: Set password (opcode 1) is accepted only when the device is unlocked.
  - With `cmd_id` 0 it stores the user password and the level (`cmd_level` 0 = high, 1 = maximum) and arms it.
  - With `cmd_id` 1 it stores the master password.
  - In the locked or frozen state it aborts and changes nothing.
- R7: Unlock (opcode 2) succeeds in two cases: `cmd_id` 0 with a matching user password, or `cmd_id` 1 with a matching master password at the high level. At the maximum level a master unlock aborts. Every unlock that aborts outside the frozen state adds one to the failure count.
- R8: Freeze (opcode 6) is accepted unless the device is locked, and it enters the frozen state. While frozen, set password, unlock, erase prepare, erase unit and disable all abort until the next `power_cycle`, and `media_ok` stays 1.
- R9: Erase unit (opcode 4) is accepted only when both of these hold:
  - it directly follows an accepted erase prepare (opcode 3);
  - the matching password is the user password or the master password, at either level.
  
  When accepted, it disarms the user password, unlocks the device and raises `wipe_pulse` in the response cycle. `wipe_pulse` is 0 for every other response.
- R10: Disable (opcode 5) is accepted only when the device is unlocked and the password matches: the user password, or the master password at the high level. It disarms the user password, so later power-ons leave the device unlocked. The master password stays stored.
- R11: After MAX_TRIES (default 5) failed unlocks, unlock, erase prepare and erase unit abort, even with a correct password, until `power_cycle`.
- R12: Opcode 7 is reserved and always aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| power_cycle | input | 1 | Power-on event; stored passwords retained |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 other, 1 set, 2 unlock, 3 prepare, 4 erase, 5 disable, 6 freeze, 7 reserved |
| cmd_id | input | 1 | 0 user password, 1 master password |
| cmd_level | input | 1 | 0 high level, 1 maximum level (set password only) |
| cmd_pw | input | NWORDS*WORD_W | Supplied password, word i at bits [16i+15:16i] |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_accept | output | 1 | 1 accepted, 0 aborted (valid with rsp_valid) |
| media_ok | output | 1 | Media access permitted |
| wipe_pulse | output | 1 | Request to erase all user data |

## Verification
Two functions can fall in the same cycle: a power-on event and the decision cycle of an in-flight command. The bench provokes this with a disable command whose password matches. It counts NWORDS+1 edges from the capture edge and then pulses `power_cycle` for exactly the edge on which the decision would be applied. The collision is judged at the ports. No response may appear (the scoreboard flags any unexpected one), `busy` must drop, and `media_ok` must read 0, which shows that the disable never took effect and the armed user password relocked the device.

// File: rtl/pwlock_pkg.sv
// Package: shared types for the password lock controller.
// Assumes a 3-bit command opcode supplied by an upstream decoder.
package pwlock_pkg;

    typedef enum logic [2:0] {
        OP_OTHER   = 3'd0,
        OP_SETPW   = 3'd1,
        OP_UNLOCK  = 3'd2,
        OP_PREP    = 3'd3,
        OP_ERASE   = 3'd4,
        OP_DISABLE = 3'd5,
        OP_FREEZE  = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_LOCKED = 2'd1,
        LK_FROZEN = 2'd2
    } lock_e;

    // Outcome of one command, applied in its decision cycle.
    typedef struct packed {
        logic  accept;
        lock_e lk_next;
        logic  wr_user;
        logic  wr_master;
        logic  clr_user;
        logic  fail_inc;
        logic  arm_prep;
        logic  wipe;
    } verdict_t;

endpackage

// File: rtl/pwlock_vault.sv
// Module: pwlock_vault
// Holds the user and master passwords, the user-armed flag and the level.
// Models non-volatile storage: only rst_n initialises it; power-on events
// are not seen here. Assumes writes arrive only in a decision cycle.
module pwlock_vault #(
    parameter int                NWORDS      = 16,
    parameter int                WORD_W      = 16,
    parameter logic [WORD_W-1:0] MASTER_SEED = 16'h5A00,
    localparam int               PW_W        = NWORDS * WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_user,
    input  logic            wr_master,
    input  logic            clr_user,
    input  logic            new_level,
    input  logic [PW_W-1:0] new_pw,
    output logic [PW_W-1:0] user_pw,
    output logic [PW_W-1:0] master_pw,
    output logic            user_set,
    output logic            level_max
);

    logic [WORD_W-1:0] user_w   [NWORDS];
    logic [WORD_W-1:0] master_w [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        // Purpose: store one word of the user password.
        always_ff @(posedge clk) begin
            if (!rst_n)
                user_w[g] <= '0;
            else if (wr_user)
                user_w[g] <= new_pw[g*WORD_W +: WORD_W];
        end

        // Purpose: store one word of the master password, seeded at init.
        always_ff @(posedge clk) begin
            if (!rst_n)
                master_w[g] <= MASTER_SEED ^ WORD_W'(g);
            else if (wr_master)
                master_w[g] <= new_pw[g*WORD_W +: WORD_W];
        end

        assign user_pw[g*WORD_W +: WORD_W]   = user_w[g];
        assign master_pw[g*WORD_W +: WORD_W] = master_w[g];
    end

    // Purpose: track whether a user password is armed and its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_set  <= 1'b0;
            level_max <= 1'b0;
        end else if (wr_user) begin
            user_set  <= 1'b1;
            level_max <= new_level;
        end else if (clr_user) begin
            user_set  <= 1'b0;
        end
    end

endmodule

// File: rtl/pwlock_cmp.sv
// Module: pwlock_cmp
// Serial word-by-word password comparator. It always walks all NWORDS
// words, so done rises NWORDS edges after start whatever the data.
// Assumes cand and refw stay stable while the walk runs.
module pwlock_cmp #(
    parameter int  NWORDS = 16,
    parameter int  WORD_W = 16,
    localparam int PW_W   = NWORDS * WORD_W,
    localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            start,
    input  logic [PW_W-1:0] cand,
    input  logic [PW_W-1:0] refw,
    output logic            done,
    output logic            equal
);

    logic          run_q;
    logic [IW-1:0] idx_q;
    logic          diff_q;
    logic [WORD_W-1:0] cand_w;
    logic [WORD_W-1:0] ref_w;

    // Purpose: pick the word pair under inspection.
    always_comb begin
        cand_w = cand[idx_q*WORD_W +: WORD_W];
        ref_w  = refw[idx_q*WORD_W +: WORD_W];
    end

    // Purpose: sequence the walk and accumulate any mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_q  <= 1'b0;
            idx_q  <= '0;
            diff_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run_q  <= 1'b1;
                idx_q  <= '0;
                diff_q <= 1'b0;
            end else if (run_q) begin
                diff_q <= diff_q | (cand_w != ref_w);
                if (idx_q == IW'(NWORDS - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                    idx_q <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign equal = !diff_q;

endmodule

// File: rtl/pwlock_policy.sv
// Module: pwlock_policy
// Pure combinational rule table: given the captured command, the current
// security state and the comparison result, it produces the verdict.
// Assumes equal refers to the password selected by cmd id.
module pwlock_policy
    import pwlock_pkg::*;
(
    input  op_e      op,
    input  logic     id,
    input  lock_e    lk,
    input  logic     user_set,
    input  logic     level_max,
    input  logic     prep_armed,
    input  logic     exhausted,
    input  logic     equal,
    output verdict_t v
);

    logic user_hit;
    logic master_hit;
    logic not_frozen_ok;

    // Purpose: qualify the raw compare result by the selected password.
    always_comb begin
        user_hit      = equal && !id && user_set;
        master_hit    = equal && id;
        not_frozen_ok = (lk != LK_FROZEN) && !exhausted;
    end

    // Purpose: map each opcode to its accept decision and side effects.
    always_comb begin
        v         = '0;
        v.lk_next = lk;
        unique case (op)
            OP_OTHER: v.accept = 1'b1;
            OP_SETPW: begin
                if (lk == LK_OPEN) begin
                    v.accept    = 1'b1;
                    v.wr_master = id;
                    v.wr_user   = !id;
                end
            end
            OP_UNLOCK: begin
                if (not_frozen_ok) begin
                    if (user_hit || (master_hit && !level_max)) begin
                        v.accept  = 1'b1;
                        v.lk_next = LK_OPEN;
                    end else begin
                        v.fail_inc = 1'b1;
                    end
                end
            end
            OP_PREP: begin
                if (not_frozen_ok) begin
                    v.accept   = 1'b1;
                    v.arm_prep = 1'b1;
                end
            end
            OP_ERASE: begin
                if (not_frozen_ok && prep_armed && (user_hit || master_hit)) begin
                    v.accept   = 1'b1;
                    v.clr_user = 1'b1;
                    v.lk_next  = LK_OPEN;
                    v.wipe     = 1'b1;
                end
            end
            OP_DISABLE: begin
                if (lk == LK_OPEN && (user_hit || (master_hit && !level_max))) begin
                    v.accept   = 1'b1;
                    v.clr_user = 1'b1;
                end
            end
            OP_FREEZE: begin
                if (lk != LK_LOCKED) begin
                    v.accept  = 1'b1;
                    v.lk_next = LK_FROZEN;
                end
            end
            default: v.accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwlock_ctrl.sv
// Module: pwlock_ctrl (top)
// Password lock controller: captures one security command at a time,
// compares its password serially, applies the rule table and returns a
// single accept/abort strobe. power_cycle models a power-on event and
// has priority over any decision in the same cycle.
// Assumes the decoder waits for rsp_valid before the next command.
module pwlock_ctrl
    import pwlock_pkg::*;
#(
    parameter int                NWORDS      = 16,
    parameter int                WORD_W      = 16,
    parameter int                MAX_TRIES   = 5,
    parameter logic [WORD_W-1:0] MASTER_SEED = 16'h5A00,
    localparam int               PW_W        = NWORDS * WORD_W,
    localparam int               TRY_W       = $clog2(MAX_TRIES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            power_cycle,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic            cmd_id,
    input  logic            cmd_level,
    input  logic [PW_W-1:0] cmd_pw,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_accept,
    output logic            media_ok,
    output logic            wipe_pulse
);

    op_e             op_q;
    logic            id_q;
    logic            lvl_q;
    logic [PW_W-1:0] pw_q;
    lock_e           lk_q;
    logic [TRY_W-1:0] fail_q;
    logic            prep_q;

    logic [PW_W-1:0] user_pw;
    logic [PW_W-1:0] master_pw;
    logic            user_set;
    logic            level_max;
    logic            cmp_done;
    logic            cmp_equal;
    logic            start;
    logic            decide;
    logic            exhausted;
    verdict_t        v;

    // Purpose: derive the capture and decision strobes.
    always_comb begin
        start     = cmd_valid && !busy && !power_cycle;
        decide    = busy && cmp_done && !power_cycle;
        exhausted = fail_q >= TRY_W'(MAX_TRIES);
    end

    // Purpose: capture a command and track the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            op_q  <= OP_OTHER;
            id_q  <= 1'b0;
            lvl_q <= 1'b0;
            pw_q  <= '0;
        end else if (power_cycle) begin
            busy <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            op_q  <= op_e'(cmd_op);
            id_q  <= cmd_id;
            lvl_q <= cmd_level;
            pw_q  <= cmd_pw;
        end else if (decide) begin
            busy <= 1'b0;
        end
    end

    pwlock_vault #(
        .NWORDS      (NWORDS),
        .WORD_W      (WORD_W),
        .MASTER_SEED (MASTER_SEED)
    ) u_vault (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_user   (decide && v.wr_user),
        .wr_master (decide && v.wr_master),
        .clr_user  (decide && v.clr_user),
        .new_level (lvl_q),
        .new_pw    (pw_q),
        .user_pw   (user_pw),
        .master_pw (master_pw),
        .user_set  (user_set),
        .level_max (level_max)
    );

    pwlock_cmp #(
        .NWORDS (NWORDS),
        .WORD_W (WORD_W)
    ) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (power_cycle),
        .start (start),
        .cand  (cmd_valid && !busy ? cmd_pw : pw_q),
        .refw  (id_q ? master_pw : user_pw),
        .done  (cmp_done),
        .equal (cmp_equal)
    );

    pwlock_policy u_policy (
        .op         (op_q),
        .id         (id_q),
        .lk         (lk_q),
        .user_set   (user_set),
        .level_max  (level_max),
        .prep_armed (prep_q),
        .exhausted  (exhausted),
        .equal      (cmp_equal),
        .v          (v)
    );

    // Purpose: hold lock state, failure count and the pending prepare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q   <= LK_OPEN;
            fail_q <= '0;
            prep_q <= 1'b0;
        end else if (power_cycle) begin
            lk_q   <= user_set ? LK_LOCKED : LK_OPEN;
            fail_q <= '0;
            prep_q <= 1'b0;
        end else if (decide) begin
            lk_q   <= v.lk_next;
            prep_q <= v.arm_prep;
            if (v.fail_inc && !exhausted)
                fail_q <= fail_q + 1'b1;
        end
    end

    // Purpose: register the response strobe, verdict and wipe request.
    always_ff @(posedge clk) begin
        if (!rst_n || power_cycle) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            wipe_pulse <= 1'b0;
        end else begin
            rsp_valid  <= decide;
            rsp_accept <= decide && v.accept;
            wipe_pulse <= decide && v.wipe;
        end
    end

    assign media_ok = (lk_q != LK_LOCKED);

endmodule

// File: rtl/pwlock_ctrl_chk.sv
// Module: pwlock_ctrl_chk
// Property checker bound to pwlock_ctrl; observes ports and state only.
module pwlock_ctrl_chk
    import pwlock_pkg::*;
#(
    parameter int MAX_TRIES = 5,
    parameter int TRY_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             power_cycle,
    input logic             cmd_valid,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_accept,
    input logic             wipe_pulse,
    input logic             media_ok,
    input logic             user_set,
    input lock_e            lk_q,
    input logic [TRY_W-1:0] fail_q
);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !power_cycle) |=> busy);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && rsp_valid));

    assert_power_drops_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        power_cycle |=> (!rsp_valid && !busy));

    assert_lock_needs_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_LOCKED) |-> user_set);

    assert_open_without_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !user_set |-> media_ok);

    assert_frozen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_FROZEN && !power_cycle) |=> (lk_q == LK_FROZEN));

    assert_wipe_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_pulse |-> (rsp_valid && rsp_accept));

    assert_tries_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q <= TRY_W'(MAX_TRIES));

endmodule

bind pwlock_ctrl pwlock_ctrl_chk #(
    .MAX_TRIES (MAX_TRIES),
    .TRY_W     (TRY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_cycle (power_cycle),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_accept  (rsp_accept),
    .wipe_pulse  (wipe_pulse),
    .media_ok    (media_ok),
    .user_set    (user_set),
    .lk_q        (lk_q),
    .fail_q      (fail_q)
);

// File: tb/pwlock_ctrl_bench.sv
// Scoreboard bench: the driver pushes expected responses, the monitor
// pops and compares them when rsp_valid appears.
module pwlock_ctrl_bench;

    localparam int NW   = 16;
    localparam int WW   = 16;
    localparam int PW_W = NW * WW;
    localparam int LAT  = NW + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            power_cycle = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = 3'd0;
    logic            cmd_id = 1'b0;
    logic            cmd_level = 1'b0;
    logic [PW_W-1:0] cmd_pw = '0;
    logic            busy, rsp_valid, rsp_accept, media_ok, wipe_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    bit    q_acc[$];
    bit    q_media[$];
    bit    q_wipe[$];
    int    q_t0[$];
    string q_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwlock_ctrl u_pwlock_ctrl (
        .clk(clk), .rst_n(rst_n), .power_cycle(power_cycle),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .cmd_level(cmd_level), .cmd_pw(cmd_pw), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .media_ok(media_ok), .wipe_pulse(wipe_pulse)
    );

    function automatic logic [PW_W-1:0] mkpw(input logic [15:0] s);
        logic [PW_W-1:0] r;
        for (int i = 0; i < NW; i++) r[i*WW +: WW] = s + 16'(i * 3);
        return r;
    endfunction

    function automatic logic [PW_W-1:0] dflt_master();
        logic [PW_W-1:0] r;
        for (int i = 0; i < NW; i++) r[i*WW +: WW] = 16'h5A00 ^ 16'(i);
        return r;
    endfunction

    function automatic logic [PW_W-1:0] flip(input logic [PW_W-1:0] p, input int w);
        logic [PW_W-1:0] r;
        r = p;
        r[w*WW] = ~r[w*WW];
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop one expectation per response and compare.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_acc.size() == 0) begin
                check("R2/R4 unexpected response", 1, 0);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " accept"}, int'(rsp_accept), int'(q_acc.pop_front()));
                check({t, " media_ok"}, int'(media_ok), int'(q_media.pop_front()));
                check({t, " wipe_pulse R9"}, int'(wipe_pulse), int'(q_wipe.pop_front()));
                check({t, " latency R2"}, cyc - q_t0.pop_front(), LAT);
            end
        end
    end

    task automatic issue(input logic [2:0] op, input bit id, input bit lvl,
                         input logic [PW_W-1:0] pw, input bit acc,
                         input bit med, input bit wp, input string tag);
        int guard;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_level = lvl; cmd_pw = pw;
        q_acc.push_back(acc); q_media.push_back(med); q_wipe.push_back(wp);
        q_t0.push_back(cyc + 1); q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (q_acc.size() > 0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 100) check({tag, " response missing"}, 0, 1);
    endtask

    task automatic pcycle(input bit exp_media, input string tag);
        @(negedge clk);
        power_cycle = 1'b1;
        @(posedge clk);
        @(negedge clk);
        power_cycle = 1'b0;
        check({tag, " media_ok after power_cycle"}, int'(media_ok), int'(exp_media));
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [PW_W-1:0] pa, pb, pc, pd, px, pm;
        pa = mkpw(16'h1111); pb = mkpw(16'h2222); pc = mkpw(16'h3333);
        pd = mkpw(16'h4444); px = mkpw(16'h7777); pm = dflt_master();

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset media_ok", int'(media_ok), 1);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset rsp_valid", int'(rsp_valid), 0);
        rst_n = 1'b1;

        // R2: a command offered while busy is ignored
        fork
            issue(3'd0, 0, 0, pa, 1, 1, 0, "R3 other cmd");
            begin
                repeat (4) @(negedge clk);
                cmd_valid = 1'b1; cmd_op = 3'd1; cmd_id = 0; cmd_pw = px;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        repeat (NW + 4) @(negedge clk);
        pcycle(1, "R2 busy cmd ignored");

        issue(3'd7, 0, 0, pa, 0, 1, 0, "R12 reserved op");
        issue(3'd1, 0, 0, pa, 1, 1, 0, "R6 set user high");
        pcycle(0, "R4 lock at power-on");
        issue(3'd0, 0, 0, px, 1, 0, 0, "R3 other while locked");
        issue(3'd1, 0, 0, px, 0, 0, 0, "R6 set while locked");
        issue(3'd6, 0, 0, px, 0, 0, 0, "R8 freeze while locked");
        issue(3'd2, 0, 0, flip(pa, NW - 1), 0, 0, 0, "R7 unlock bad last word");
        issue(3'd2, 0, 0, flip(pa, 0), 0, 0, 0, "R7 unlock bad first word");
        issue(3'd2, 1, 0, pm, 1, 1, 0, "R7 master unlock high");
        issue(3'd6, 0, 0, px, 1, 1, 0, "R8 freeze");
        issue(3'd1, 0, 0, px, 0, 1, 0, "R8 set while frozen");
        issue(3'd2, 0, 0, pa, 0, 1, 0, "R8 unlock while frozen");
        issue(3'd3, 0, 0, pa, 0, 1, 0, "R8 prepare while frozen");
        issue(3'd5, 0, 0, pa, 0, 1, 0, "R8 disable while frozen");
        issue(3'd4, 0, 0, pa, 0, 1, 0, "R8 erase while frozen");
        pcycle(0, "R4 relock after frozen");
        issue(3'd2, 0, 0, pa, 1, 1, 0, "R7 user unlock");
        issue(3'd1, 1, 0, pb, 1, 1, 0, "R6 set master");
        issue(3'd1, 0, 1, pa, 1, 1, 0, "R6 set user max");
        pcycle(0, "R4 lock max level");
        issue(3'd2, 1, 0, pb, 0, 0, 0, "R7 master unlock at max");
        issue(3'd4, 1, 0, pb, 0, 0, 0, "R9 erase without prepare");
        issue(3'd3, 1, 0, pb, 1, 0, 0, "R9 prepare");
        issue(3'd0, 0, 0, px, 1, 0, 0, "R3 other cancels prepare");
        issue(3'd4, 1, 0, pb, 0, 0, 0, "R3 erase after cancel");
        issue(3'd3, 1, 0, pb, 1, 0, 0, "R9 prepare again");
        issue(3'd4, 1, 0, pb, 1, 1, 1, "R9 master erase at max");
        pcycle(1, "R9 no user after erase");
        issue(3'd1, 0, 0, pc, 1, 1, 0, "R6 set user C");
        issue(3'd5, 0, 0, flip(pc, 7), 0, 1, 0, "R10 disable wrong pw");
        issue(3'd5, 0, 0, pc, 1, 1, 0, "R10 disable");
        pcycle(1, "R10 open after disable");
        issue(3'd1, 0, 0, pd, 1, 1, 0, "R6 set user D");
        pcycle(0, "R4 lock user D");
        issue(3'd2, 1, 0, pb, 1, 1, 0, "R10 master kept after disable");

        // R4: power_cycle on the decision edge of a matching disable
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_id = 0; cmd_pw = pd;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (NW) @(posedge clk);
        @(negedge clk);
        power_cycle = 1'b1;
        @(posedge clk);
        @(negedge clk);
        power_cycle = 1'b0;
        check("R4 collision rsp_valid", int'(rsp_valid), 0);
        check("R4 collision busy", int'(busy), 0);
        check("R4 collision media_ok (disable dropped)", int'(media_ok), 0);
        repeat (NW + 4) @(negedge clk);

        for (int i = 0; i < 5; i++)
            issue(3'd2, 0, 0, flip(pd, i), 0, 0, 0, "R11 failed unlock");
        issue(3'd2, 0, 0, pd, 0, 0, 0, "R11 unlock when exhausted");
        issue(3'd3, 0, 0, pd, 0, 0, 0, "R11 prepare when exhausted");
        pcycle(0, "R11 power clears count");
        issue(3'd2, 0, 0, pd, 1, 1, 0, "R11 unlock after power_cycle");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule